// File: doc/BRIEF.md
# Receive Cell Bus Output Stage

This block sits between a receive cell buffer and an ATM layer device. It moves cells out of the buffer onto a receive data bus one transfer at a time. The bus is either 8 or 16 bits wide. Each transfer carries one byte or one 16-bit word, together with an odd-parity bit, and a start-of-cell strobe marks the first transfer of every cell. The cell length is 52, 53 or 54 bytes. The ATM layer paces the flow with an active-low read enable. A cell-available output tells the ATM layer whether data is waiting. It falls when nothing more can be read.

Upstream, the buffer presents data with a valid/ready handshake. It also raises a flag while it holds at least one complete cell. A new cell starts only while that flag is high. Once a cell has started, the block moves it to its end without checking the flag again. Back-pressure works as follows. `in_ready` is high only while `rd_en_n` is low and either a cell is in progress or a full cell is buffered. A word is consumed on a rising edge where both `in_valid` and `in_ready` are high. `in_ready` never depends on `in_valid`.

Top module: `rx_cellbus_out`

## Requirements
- R1: A synchronous active-high reset clears the word position. After reset, `out_valid` and `out_soc` are 0, `out_data` is 0 and `out_par` is 1.
- R2: `in_ready` = !`rd_en_n` && (cell in progress || `cell_avail`). A transfer takes place on a rising edge only when `in_ready` and `in_valid` are both high. In the cycle after a transfer, `out_valid` is 1. In any other cycle it is 0.
- R3: While `rd_en_n` is high, `out_data`, `out_par` and `out_soc` keep their values across the edge, and `out_valid` becomes 0.
- R4: The number of 1 bits in the transferred data plus `out_par` is always odd.
- R5: In 8-bit mode (`cfg_wide`=0), `out_data[15:8]` is driven to 0 and the parity covers bits 7:0. In 16-bit mode (`cfg_wide`=1), all 16 bits are passed through and covered.
- R6: `out_soc` is 1 after the transfer that carries the first byte or word of a cell, and 0 after every other transfer.
- R7: In 8-bit mode, `cfg_len` values 0, 1 and 2 give cells of 52, 53 and 54 transfers. The value 3 gives 54 transfers.
- R8: In 16-bit mode, `cfg_len`=0 gives 26 transfers. All other `cfg_len` values give 27 transfers, because 53 bytes round up to 54.
- R9: `cfg_wide` and `cfg_len` are sampled only at the first transfer of a cell. Changes in the middle of a cell do not affect that cell's length or width.
- R10: `bus_clav` = (cell in progress || `cell_avail`). A cell that has started continues even while `cell_avail` is low, and no new cell begins before the last transfer of the previous one.
- R11: If `rd_en_n` is low and no transfer occurs, `out_data` and `out_par` hold, while `out_valid` and `out_soc` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_len | input | 2 | Cell length select: 0=52, 1=53, 2/3=54 bytes |
| cell_avail | input | 1 | Buffer holds at least one complete cell |
| in_valid | input | 1 | Upstream word valid |
| in_data | input | 16 | Upstream byte (low 8 bits) or word |
| in_ready | output | 1 | Pop strobe to the upstream buffer |
| rd_en_n | input | 1 | Read enable from the ATM layer, active low |
| bus_clav | output | 1 | Cell data can be read |
| out_data | output | 16 | Receive bus data |
| out_par | output | 1 | Odd parity of out_data |
| out_soc | output | 1 | Start-of-cell strobe |
| out_valid | output | 1 | A transfer landed on the bus last edge |

## Verification
If the word position counter is wrong, the next `out_soc` arrives early or late. That shows at the ports within one cell of 26 to 54 transfers. A wrong in-progress state shows at once on `in_ready` and `bus_clav` in any cycle where `cell_avail` is low. A wrong latched width corrupts the upper data byte or the parity on the very next transfer. The bench therefore checks every cycle against its own model, and changes the configuration in the middle of cells.

// File: rtl/rxcb_pkg.sv
package rxcb_pkg;
  localparam int BASE_BYTES = 52;

  // transfers per cell for a width mode and length code
  function automatic int cell_words(input logic wide, input logic [1:0] len);
    int bytes;
    bytes = BASE_BYTES + ((len == 2'd0) ? 0 : (len == 2'd1) ? 1 : 2);
    if (wide) begin
      if (bytes % 2 != 0) bytes = bytes + 1;
      return bytes / 2;
    end
    return bytes;
  endfunction
endpackage

// File: rtl/rxcb_len_sel.sv
module rxcb_len_sel #(
  parameter int CNT_W = 6
) (
  input  logic             wide,
  input  logic [1:0]       len,
  output logic [CNT_W-1:0] words
);
  always_comb begin
    words = CNT_W'(rxcb_pkg::cell_words(wide, len));
  end
endmodule

// File: rtl/rxcb_word_ctr.sv
module rxcb_word_ctr #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [CNT_W-1:0] words_in,
  output logic             mid
);
  logic [CNT_W-1:0] cnt_q, lim_q, lim_cur, nxt;

  assign mid     = (cnt_q != '0);
  assign lim_cur = mid ? lim_q : words_in;
  assign nxt     = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else if (adv) begin
      if (!mid) lim_q <= words_in;
      cnt_q <= (nxt == lim_cur) ? '0 : nxt;
    end
  end
endmodule

// File: rtl/rxcb_parity.sv
module rxcb_parity #(
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic [LANE_W*LANES-1:0] data,
  input  logic                    wide,
  output logic                    par
);
  logic [LANES-1:0] lane_p;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_p[i] = ^data[i*LANE_W +: LANE_W];
  end

  assign par = ~(wide ? ^lane_p : lane_p[0]);
endmodule

// File: rtl/rx_cellbus_out.sv
module rx_cellbus_out #(
  parameter int NARROW_W = 8,
  parameter int LANES    = 2,
  parameter int CNT_W    = 6,
  localparam int BUS_W   = NARROW_W * LANES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_wide,
  input  logic [1:0]       cfg_len,
  input  logic             cell_avail,
  input  logic             in_valid,
  input  logic [BUS_W-1:0] in_data,
  output logic             in_ready,
  input  logic             rd_en_n,
  output logic             bus_clav,
  output logic [BUS_W-1:0] out_data,
  output logic             out_par,
  output logic             out_soc,
  output logic             out_valid
);
  logic             mid, xfer, wide_q, wide_eff, nxt_par;
  logic [CNT_W-1:0] words;
  logic [BUS_W-1:0] nxt_data;

  assign bus_clav = mid | cell_avail;
  assign in_ready = ~rd_en_n & bus_clav;
  assign xfer     = in_ready & in_valid;
  assign wide_eff = mid ? wide_q : cfg_wide;
  assign nxt_data = wide_eff ? in_data
                             : {{(BUS_W-NARROW_W){1'b0}}, in_data[NARROW_W-1:0]};

  rxcb_len_sel #(.CNT_W(CNT_W)) u_len (
    .wide(cfg_wide), .len(cfg_len), .words(words));

  rxcb_word_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .adv(xfer), .words_in(words), .mid(mid));

  rxcb_parity #(.LANE_W(NARROW_W), .LANES(LANES)) u_par (
    .data(nxt_data), .wide(wide_eff), .par(nxt_par));

  always_ff @(posedge clk) begin
    if (rst) begin
      wide_q    <= 1'b0;
      out_data  <= '0;
      out_par   <= 1'b1;
      out_soc   <= 1'b0;
      out_valid <= 1'b0;
    end else if (xfer) begin
      if (!mid) wide_q <= cfg_wide;
      out_data  <= nxt_data;
      out_par   <= nxt_par;
      out_soc   <= ~mid;
      out_valid <= 1'b1;
    end else if (rd_en_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_soc   <= 1'b0;
    end
  end
endmodule

// File: rtl/rxcb_checker.sv
module rxcb_checker (
  input logic        clk,
  input logic        rst,
  input logic        rd_en_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        bus_clav,
  input logic        wide_q,
  input logic [15:0] out_data,
  input logic        out_par,
  input logic        out_soc,
  input logic        out_valid
);
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    rd_en_n |=> ($stable(out_data) && $stable(out_par) && $stable(out_soc) && !out_valid));

  a_r4_odd_parity: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (^{out_data, out_par}) == 1'b1);

  a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !wide_q) |-> out_data[15:8] == 8'h00);

  a_r2_no_xfer: assert property (@(posedge clk) disable iff (rst)
    (!in_valid || !in_ready) |=> !out_valid);

  a_r10_ready_needs_clav: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> bus_clav);

  a_r11_stall: assert property (@(posedge clk) disable iff (rst)
    (!rd_en_n && !(in_valid && in_ready)) |=> (!out_soc && !out_valid && $stable(out_data)));
endmodule

bind rx_cellbus_out rxcb_checker u_chk (
  .clk(clk), .rst(rst), .rd_en_n(rd_en_n), .in_valid(in_valid),
  .in_ready(in_ready), .bus_clav(bus_clav), .wide_q(wide_q),
  .out_data(out_data), .out_par(out_par), .out_soc(out_soc),
  .out_valid(out_valid));

// File: tb/rx_cellbus_out_bench.sv
module rx_cellbus_out_bench;
  logic clk = 1'b0;
  logic rst, cfg_wide, cell_avail, in_valid, rd_en_n;
  logic [1:0]  cfg_len;
  logic [15:0] in_data;
  logic in_ready, bus_clav, out_par, out_soc, out_valid;
  logic [15:0] out_data;

  int n_cmp = 0, n_bad = 0;

  // model state
  int m_cnt = 0, m_words = 0;
  logic [15:0] m_data = 16'h0;
  logic m_par = 1'b1, m_soc = 1'b0, m_valid = 1'b0, m_wide = 1'b0;

  always #10 clk = ~clk;

  rx_cellbus_out u_rx_cellbus_out (
    .clk(clk), .rst(rst), .cfg_wide(cfg_wide), .cfg_len(cfg_len),
    .cell_avail(cell_avail), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .rd_en_n(rd_en_n), .bus_clav(bus_clav),
    .out_data(out_data), .out_par(out_par), .out_soc(out_soc),
    .out_valid(out_valid));

  function automatic int exp_words(input logic w, input logic [1:0] l);
    if (w) return (l == 2'd0) ? 26 : 27;
    return (l == 2'd0) ? 52 : (l == 2'd1) ? 53 : 54;
  endfunction

  function automatic logic odd_par(input logic [15:0] d);
    return ~(^d);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // drive inputs at negedge, check comb outputs, then check registered outputs after edge
  task automatic step(input logic en_n, input logic v, input logic av,
                      input logic [15:0] d, input logic w, input logic [1:0] l);
    logic mid, rdy, xf;
    @(negedge clk);
    rd_en_n = en_n; in_valid = v; cell_avail = av; in_data = d;
    cfg_wide = w; cfg_len = l;
    #1;
    mid = (m_cnt != 0);
    rdy = !en_n && (mid || av);
    xf  = rdy && v;
    chk("R2 in_ready", {31'b0, in_ready}, {31'b0, rdy});
    chk("R10 bus_clav", {31'b0, bus_clav}, {31'b0, mid || av});
    if (xf) begin
      if (!mid) begin
        m_wide  = w;
        m_words = exp_words(w, l);
      end
      m_data  = m_wide ? d : {8'h00, d[7:0]};
      m_par   = odd_par(m_data);
      m_soc   = !mid;
      m_valid = 1'b1;
      m_cnt   = (m_cnt + 1 == m_words) ? 0 : m_cnt + 1;
    end else begin
      m_valid = 1'b0;
      if (!en_n) m_soc = 1'b0;
    end
    @(posedge clk);
    #1;
    chk("R2 out_valid", {31'b0, out_valid}, {31'b0, m_valid});
    chk("R5 out_data", {16'b0, out_data}, {16'b0, m_data});
    chk("R4 out_par", {31'b0, out_par}, {31'b0, m_par});
    chk("R6 out_soc", {31'b0, out_soc}, {31'b0, m_soc});
  endtask

  // one full cell streamed without gaps; returns transfers seen until next soc
  task automatic cell_len_check(input logic w, input logic [1:0] l, input string req);
    int seen;
    step(1'b0, 1'b1, 1'b1, 16'hA5C3, w, l);
    chk({req, " first soc"}, {31'b0, out_soc}, 32'd1);
    seen = 1;
    while (m_cnt != 0) begin
      // flip config mid-cell to exercise R9; cell_avail low to exercise R10
      step(1'b0, 1'b1, 1'b0, 16'($urandom), ~w, 2'(l + 1));
      seen++;
    end
    chk({req, " length"}, seen, exp_words(w, l));
  endtask

  initial begin
    #4000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst = 1'b1; rd_en_n = 1'b1; in_valid = 1'b0; cell_avail = 1'b0;
    in_data = 16'h0; cfg_wide = 1'b0; cfg_len = 2'd0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 out_valid", {31'b0, out_valid}, 32'd0);
    chk("R1 out_soc", {31'b0, out_soc}, 32'd0);
    chk("R1 out_data", {16'b0, out_data}, 32'd0);
    chk("R1 out_par", {31'b0, out_par}, 32'd1);
    chk("R1 clav", {31'b0, bus_clav}, 32'd0);
    @(negedge clk); rst = 1'b0;

    // R7 narrow lengths, R8 wide lengths, R9 mid-cell config change
    cell_len_check(1'b0, 2'd0, "R7 52");
    cell_len_check(1'b0, 2'd1, "R7 53");
    cell_len_check(1'b0, 2'd2, "R7 54");
    cell_len_check(1'b0, 2'd3, "R7 len3");
    cell_len_check(1'b1, 2'd0, "R8 26");
    cell_len_check(1'b1, 2'd1, "R8 53->27");
    cell_len_check(1'b1, 2'd2, "R8 27");
    cell_len_check(1'b0, 2'd1, "R9 after wide");

    // R3 hold with enable high mid-cell
    step(1'b0, 1'b1, 1'b1, 16'hFFFF, 1'b1, 2'd2);
    step(1'b1, 1'b1, 1'b1, 16'h1234, 1'b1, 2'd2);
    chk("R3 hold data", {16'b0, out_data}, 32'h0000FFFF);
    chk("R3 hold soc", {31'b0, out_soc}, 32'd1);
    // R11 stall with enable low, no valid
    step(1'b0, 1'b0, 1'b1, 16'h5555, 1'b1, 2'd2);
    chk("R11 stall soc", {31'b0, out_soc}, 32'd0);
    chk("R11 stall data", {16'b0, out_data}, 32'h0000FFFF);
    // R10 no cell start without cell_avail
    while (m_cnt != 0) step(1'b0, 1'b1, 1'b0, 16'($urandom), 1'b1, 2'd2);
    step(1'b0, 1'b1, 1'b0, 16'h7777, 1'b0, 2'd0);
    chk("R10 no start", {31'b0, out_valid}, 32'd0);

    // random phase
    for (int i = 0; i < 30000; i++) begin
      step(($urandom % 4) == 0, ($urandom % 5) != 0, ($urandom % 2) == 0,
           16'($urandom), 1'($urandom), 2'($urandom));
    end

    // reset mid-cell: R1
    step(1'b0, 1'b1, 1'b1, 16'h00F0, 1'b0, 2'd0);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 reset soc", {31'b0, out_soc}, 32'd0);
    chk("R1 reset valid", {31'b0, out_valid}, 32'd0);
    @(negedge clk); rst = 1'b0; cell_avail = 1'b0; #1;
    chk("R1 reset clav", {31'b0, bus_clav}, 32'd0);
    m_cnt = 0; m_data = 16'h0; m_par = 1'b1; m_soc = 1'b0; m_valid = 1'b0;
    cell_len_check(1'b1, 2'd0, "R1 after reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule